// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Status Flags

This block is the 8-bit datapath that sits between the accumulator and the operand latch of a small processor core. On every clock it takes an operation code, the current accumulator value, a second operand and the current status byte. One clock later it presents the result, a strobe that tells the register file whether to write the accumulator, and the new status byte. The status byte holds five condition bits: sign, zero, half carry, parity and carry/borrow.

Each operation class has its own rule for which condition bits it touches. Arithmetic updates all five. Increment and decrement leave carry alone. Bitwise operations force carry and half carry low. Complement touches nothing. Rotates alter only carry. Compare works out the difference but never writes it back, so it can set up conditional branches. Operation codes that are not assigned act as a pass-through and change nothing.

The asynchronous active-low reset is synchronised inside the block. The output register comes out of reset two clocks after `rst_n` rises.

Top module: `acc_alu`

## Requirements
- R1: While reset is held, the outputs are result 0x00, write strobe 0 and status byte 0x02.
- R2: Outputs change only at a rising clock edge, and they reflect the inputs sampled at that edge (one cycle of latency).
- R3: Code 0 (add) gives A+B and code 1 (subtract) gives A−B, modulo 256. Carry is the carry out of bit 7 for add and the borrow (A<B) for subtract. Both write A.
- R4: For arithmetic, increment, decrement and bitwise codes, S equals result bit 7, Z is set when the result is 0x00, and P is set when the result has an even number of ones.
- R5: Half carry is set when bit 3 carries into bit 4. For subtract, compare and decrement it is the bit-3 carry of A plus the two's complement of the subtrahend, which means it is set when no borrow comes out of the low nibble.
- R6: Codes 4, 5 and 6 (AND, OR, XOR with B) clear both carry and half carry and write A.
- R7: Code 7 inverts A, writes it, and leaves the status bits equal to the incoming ones.
- R8: Code 8 (compare) does not write A. It sets CY=1 and Z=0 when A<B, CY=0 and Z=1 when A=B, and CY=0 and Z=0 when A>B. S, P and half carry are set as for subtract.
- R9: Code 2 gives A+1 and code 3 gives A−1. Both write A, update S, Z, P and half carry, and keep carry unchanged.
- R10: Code 9 rotates A left with bit 7 into bit 0 and into CY. Code 10 rotates right with bit 0 into bit 7 and into CY. Code 11 rotates left through carry and code 12 rotates right through carry. Rotates change no status bit other than CY.
- R11: Codes 13 to 15 do not write A. They return A as the result and pass the status bits through.
- R12: The status byte is laid out from bit 7 to bit 0 as S, Z, 0, AC, 0, P, 1, CY. The fixed bits hold their value whatever `flags_i` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value (A) |
| opnd_i | input | 8 | Temporary operand (B) |
| flags_i | input | 8 | Current status byte |
| result_o | output | 8 | Registered result |
| acc_we_o | output | 1 | Registered accumulator write strobe |
| flags_o | output | 8 | Registered updated status byte |

## Verification
The bench aims at the nibble boundaries: 0x0F+0x01, 0xFF+0x01, and equal low nibbles on subtract. A half-carry term that is taken from the wrong bit, or that is not inverted for the borrow case, gives wrong AC values there. Compare is run with A below, equal to and above B, so a design that writes A back or inverts the borrow sense gets caught. The carry-through rotates are driven with both carry-in values, because a design that copies the bit it shifted out instead of the old carry only fails when those two differ. Increment at 0xFF and complement are run with carry set, so any rule that disturbs bits it should keep shows up at the output.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_INC  = 4'd2,
    OP_DEC  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_CMA  = 4'd7,
    OP_CMP  = 4'd8,
    OP_RLC  = 4'd9,
    OP_RRC  = 4'd10,
    OP_RAL  = 4'd11,
    OP_RAR  = 4'd12,
    OP_PS0  = 4'd13,
    OP_PS1  = 4'd14,
    OP_PS2  = 4'd15
  } alu_op_e;

  // status byte bit positions
  localparam int FB_S   = 7;
  localparam int FB_Z   = 6;
  localparam int FB_Z5  = 5;
  localparam int FB_AC  = 4;
  localparam int FB_Z3  = 3;
  localparam int FB_P   = 2;
  localparam int FB_ONE = 1;
  localparam int FB_CY  = 0;
  localparam int FB_W   = 8;

  localparam logic [FB_W-1:0] FB_KEEP_MASK = 8'hD5;
  localparam logic [FB_W-1:0] FB_SET_MASK  = 8'h02;

  function automatic logic is_arith(input alu_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_INC) ||
           (op == OP_DEC) || (op == OP_CMP);
  endfunction

  function automatic logic is_bitwise(input alu_op_e op);
    return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
  endfunction

  function automatic logic is_rotate(input alu_op_e op);
    return (op == OP_RLC) || (op == OP_RRC) || (op == OP_RAL) || (op == OP_RAR);
  endfunction

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         hc_o
);
  localparam int HI = W - NIB;

  logic [NIB:0] lo_sum;
  logic [HI:0]  hi_sum;

  always_comb begin
    lo_sum = {1'b0, a_i[NIB-1:0]} + {1'b0, b_i[NIB-1:0]} + {{NIB{1'b0}}, cin_i};
    hi_sum = {1'b0, a_i[W-1:NIB]} + {1'b0, b_i[W-1:NIB]} + {{HI{1'b0}}, lo_sum[NIB]};
  end

  assign sum_o  = {hi_sum[HI-1:0], lo_sum[NIB-1:0]};
  assign cout_o = hi_sum[HI];
  assign hc_o   = lo_sum[NIB];

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cy_i,
  output logic [W-1:0] res_o,
  output logic         rot_cy_o
);
  always_comb begin
    res_o    = a_i;
    rot_cy_o = cy_i;
    unique case (op_i)
      OP_AND: res_o = a_i & b_i;
      OP_OR:  res_o = a_i | b_i;
      OP_XOR: res_o = a_i ^ b_i;
      OP_CMA: res_o = ~a_i;
      OP_RLC: begin
        res_o    = {a_i[W-2:0], a_i[W-1]};
        rot_cy_o = a_i[W-1];
      end
      OP_RRC: begin
        res_o    = {a_i[0], a_i[W-1:1]};
        rot_cy_o = a_i[0];
      end
      OP_RAL: begin
        res_o    = {a_i[W-2:0], cy_i};
        rot_cy_o = a_i[W-1];
      end
      OP_RAR: begin
        res_o    = {cy_i, a_i[W-1:1]};
        rot_cy_o = a_i[0];
      end
      default: begin
        res_o    = a_i;
        rot_cy_o = cy_i;
      end
    endcase
  end

endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e         op_i,
  input  logic [W-1:0]    res_i,
  input  logic            cout_i,
  input  logic            hc_i,
  input  logic            rot_cy_i,
  input  logic [FB_W-1:0] flags_i,
  output logic [FB_W-1:0] flags_o
);
  logic sign_v, zero_v, par_v;

  always_comb begin
    sign_v = res_i[W-1];
    zero_v = (res_i == '0);
    par_v  = 1'b1;
    for (int i = 0; i < W; i++) begin
      par_v = par_v ^ res_i[i];
    end
  end

  always_comb begin
    flags_o = (flags_i & FB_KEEP_MASK) | FB_SET_MASK;
    if (is_arith(op_i) || is_bitwise(op_i)) begin
      flags_o[FB_S] = sign_v;
      flags_o[FB_Z] = zero_v;
      flags_o[FB_P] = par_v;
    end
    unique case (op_i)
      OP_ADD: begin
        flags_o[FB_CY] = cout_i;
        flags_o[FB_AC] = hc_i;
      end
      OP_SUB, OP_CMP: begin
        flags_o[FB_CY] = ~cout_i;
        flags_o[FB_AC] = hc_i;
      end
      OP_INC, OP_DEC: flags_o[FB_AC] = hc_i;
      OP_AND, OP_OR, OP_XOR: begin
        flags_o[FB_CY] = 1'b0;
        flags_o[FB_AC] = 1'b0;
      end
      OP_RLC, OP_RRC, OP_RAL, OP_RAR: flags_o[FB_CY] = rot_cy_i;
      default: ;
    endcase
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W           = 8,
  parameter int NIB         = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic [7:0]   flags_i,
  output logic [W-1:0] result_o,
  output logic         acc_we_o,
  output logic [7:0]   flags_o
);
  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  alu_op_e     op;
  logic [W-1:0] add_b;
  logic         add_cin;
  logic [W-1:0] sum;
  logic         cout, hc;
  logic [W-1:0] lres;
  logic         rot_cy;
  logic [7:0]   flags_d;
  logic [W-1:0] result_d;
  logic         we_d;

  assign op = alu_op_e'(op_i);

  // second adder input per operation
  always_comb begin
    add_b   = opnd_i;
    add_cin = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: begin add_b = ~opnd_i; add_cin = 1'b1; end
      OP_INC:         begin add_b = '0;      add_cin = 1'b1; end
      OP_DEC:         begin add_b = '1;      add_cin = 1'b0; end
      default:        begin add_b = opnd_i;  add_cin = 1'b0; end
    endcase
  end

  acc_alu_addsub #(.W(W), .NIB(NIB)) u_addsub (
    .a_i    (acc_i),
    .b_i    (add_b),
    .cin_i  (add_cin),
    .sum_o  (sum),
    .cout_o (cout),
    .hc_o   (hc)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .op_i     (op),
    .a_i      (acc_i),
    .b_i      (opnd_i),
    .cy_i     (flags_i[FB_CY]),
    .res_o    (lres),
    .rot_cy_o (rot_cy)
  );

  always_comb begin
    result_d = is_arith(op) ? sum : lres;
    we_d     = (op != OP_CMP) && (op_i < 4'd13);
  end

  acc_alu_flags #(.W(W)) u_flags (
    .op_i     (op),
    .res_i    (result_d),
    .cout_i   (cout),
    .hc_i     (hc),
    .rot_cy_i (rot_cy),
    .flags_i  (flags_i),
    .flags_o  (flags_d)
  );

  logic out_en;
  assign out_en = 1'b1;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      result_o <= '0;
      acc_we_o <= 1'b0;
      flags_o  <= FB_SET_MASK;
    end else if (out_en) begin
      result_o <= result_d;
      acc_we_o <= we_d;
      flags_o  <= flags_d;
    end
  end

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic [3:0]   op_i,
  input logic [W-1:0] acc_i,
  input logic [7:0]   flags_i,
  input logic [W-1:0] result_o,
  input logic         acc_we_o,
  input logic [7:0]   flags_o
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) seen_q <= 1'b0;
    else             seen_q <= 1'b1;
  end

  // R12: fixed bits of the status byte
  a_r12_fixed_bits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    seen_q |-> (flags_o[5] == 1'b0 && flags_o[3] == 1'b0 && flags_o[1] == 1'b1));

  // R8: compare never writes A
  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen_q && $past(op_i) == 4'd8) |-> !acc_we_o);

  // R6: bitwise ops clear CY and AC
  a_r6_logic_clears_cy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen_q && ($past(op_i) == 4'd4 || $past(op_i) == 4'd5 || $past(op_i) == 4'd6))
      |-> (flags_o[0] == 1'b0 && flags_o[4] == 1'b0));

  // R7: complement keeps status bits
  a_r7_cma_keeps_flags: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen_q && $past(op_i) == 4'd7)
      |-> (result_o == ~$past(acc_i) && flags_o == (($past(flags_i) & 8'hD5) | 8'h02)));

  // R9: increment and decrement keep CY
  a_r9_incdec_keep_cy: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen_q && ($past(op_i) == 4'd2 || $past(op_i) == 4'd3))
      |-> (flags_o[0] == $past(flags_i[0])));

  // R10: left rotate moves bit 7 to bit 0 and CY
  a_r10_rlc: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen_q && $past(op_i) == 4'd9)
      |-> (result_o == {$past(acc_i[W-2:0]), $past(acc_i[W-1])} &&
           flags_o[0] == $past(acc_i[W-1]) &&
           flags_o[7:1] == (($past(flags_i[7:1]) & 7'h6A) | 7'h01)));

  // R11: unassigned codes pass through
  a_r11_pass: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen_q && $past(op_i) >= 4'd13)
      |-> (!acc_we_o && result_o == $past(acc_i)));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_acc_alu_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .op_i       (op_i),
  .acc_i      (acc_i),
  .flags_i    (flags_i),
  .result_o   (result_o),
  .acc_we_o   (acc_we_o),
  .flags_o    (flags_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op;
  logic [7:0] a, b, f;
  logic [7:0] result;
  logic       we;
  logic [7:0] flags;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  acc_alu dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op),
    .acc_i    (a),
    .opnd_i   (b),
    .flags_i  (f),
    .result_o (result),
    .acc_we_o (we),
    .flags_o  (flags)
  );

  // expected {result, write, status}
  function automatic logic [16:0] model(input logic [3:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic [7:0] fi);
    logic [7:0] r;
    logic w, s, z, ac, p, cy, upd;
    int t;
    s = fi[7]; z = fi[6]; ac = fi[4]; p = fi[2]; cy = fi[0];
    w = 1'b1; upd = 1'b0; r = x;
    case (o)
      4'd0: begin t = x + y; r = t[7:0]; cy = t[8]; ac = ((x & 15) + (y & 15)) > 15; upd = 1; end
      4'd1, 4'd8: begin r = x - y; cy = (x < y); ac = ((x & 15) >= (y & 15)); upd = 1; w = (o != 4'd8); end
      4'd2: begin r = x + 8'd1; ac = ((x & 15) == 15); upd = 1; end
      4'd3: begin r = x - 8'd1; ac = ((x & 15) != 0); upd = 1; end
      4'd4: begin r = x & y; cy = 0; ac = 0; upd = 1; end
      4'd5: begin r = x | y; cy = 0; ac = 0; upd = 1; end
      4'd6: begin r = x ^ y; cy = 0; ac = 0; upd = 1; end
      4'd7: r = ~x;
      4'd9:  begin r = {x[6:0], x[7]}; cy = x[7]; end
      4'd10: begin r = {x[0], x[7:1]}; cy = x[0]; end
      4'd11: begin r = {x[6:0], fi[0]}; cy = x[7]; end
      4'd12: begin r = {fi[0], x[7:1]}; cy = x[0]; end
      default: begin r = x; w = 1'b0; end
    endcase
    if (upd) begin
      s = r[7]; z = (r == 8'h00); p = ~(^r);
    end
    return {r, w, s, z, 1'b0, ac, 1'b0, p, 1'b1, cy};
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R9";
      4'd4, 4'd5, 4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      4'd9, 4'd10, 4'd11, 4'd12: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic compare(input string tag, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: op=%0d a=%h b=%h f=%h got=%h expected=%h", tag, op, a, b, f, got, exp);
    end
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic run(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                     input logic [7:0] fi, input string tag);
    logic [16:0] exp;
    @(negedge clk);
    op = o; a = x; b = y; f = fi;
    exp = model(o, x, y, fi);
    @(negedge clk);
    compare(tag.len() == 0 ? tag_of(o) : tag, {result, we, flags}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0A1B));
    rst_n = 1'b0; op = 4'd0; a = 8'h12; b = 8'h34; f = 8'hFF;
    repeat (3) @(negedge clk);
    compare("R1", {result, we, flags}, {8'h00, 1'b0, 8'h02});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2: latency of one edge
    run(4'd0, 8'h01, 8'h01, 8'h00, "R2");
    op = 4'd0; a = 8'h03; b = 8'h03;
    #1;
    compare("R2", {result, we}, {8'h02, 1'b1});
    @(negedge clk);
    compare("R2", {result, we, flags}, model(4'd0, 8'h03, 8'h03, 8'h00));

    // R3 add/sub carries and borrows
    run(4'd0, 8'hFF, 8'h01, 8'h00, "R3");
    run(4'd1, 8'h10, 8'h20, 8'h00, "R3");
    run(4'd1, 8'h20, 8'h10, 8'h01, "R3");
    // R5 half carry boundaries
    run(4'd0, 8'h0F, 8'h01, 8'h00, "R5");
    run(4'd0, 8'h10, 8'h10, 8'h10, "R5");
    run(4'd1, 8'h35, 8'h05, 8'h00, "R5");
    run(4'd3, 8'h10, 8'h00, 8'h00, "R5");
    // R4 sign, zero, parity
    run(4'd4, 8'hFF, 8'h03, 8'h00, "R4");
    run(4'd5, 8'h80, 8'h01, 8'h00, "R4");
    run(4'd6, 8'h07, 8'h00, 8'h00, "R4");
    run(4'd6, 8'h5A, 8'h5A, 8'h00, "R4");
    // R6 bitwise clears carry
    run(4'd5, 8'h00, 8'h00, 8'hFF, "R6");
    // R7 complement keeps flags
    run(4'd7, 8'hA5, 8'h00, 8'hD5, "R7");
    run(4'd7, 8'h00, 8'h00, 8'h00, "R7");
    // R8 compare three outcomes
    run(4'd8, 8'h10, 8'h20, 8'h00, "R8");
    run(4'd8, 8'h42, 8'h42, 8'h01, "R8");
    run(4'd8, 8'h90, 8'h20, 8'h41, "R8");
    // R9 inc/dec keep carry
    run(4'd2, 8'hFF, 8'h00, 8'h01, "R9");
    run(4'd3, 8'h00, 8'h00, 8'h00, "R9");
    // R10 rotates with both carry-in values
    run(4'd9, 8'h81, 8'h00, 8'hD4, "R10");
    run(4'd10, 8'h01, 8'h00, 8'h00, "R10");
    run(4'd11, 8'h40, 8'h00, 8'h01, "R10");
    run(4'd11, 8'hC0, 8'h00, 8'h00, "R10");
    run(4'd12, 8'h02, 8'h00, 8'h01, "R10");
    run(4'd12, 8'h03, 8'h00, 8'h00, "R10");
    // R11 pass-through codes
    run(4'd13, 8'h66, 8'h11, 8'h95, "R11");
    run(4'd15, 8'h00, 8'hFF, 8'h00, "R11");
    // R12 fixed bits under all-ones and all-zeros status input
    run(4'd14, 8'h01, 8'h01, 8'hFF, "R12");
    run(4'd7, 8'h01, 8'h01, 8'h00, "R12");

    for (int i = 0; i < 3000; i++) begin
      run(4'($urandom_range(15, 0)), 8'($urandom), 8'($urandom), 8'($urandom), "");
    end

    // R1 again: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    compare("R1", {result, we, flags}, {8'h00, 1'b0, 8'h02});
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule